// File: doc/BRIEF.md
# Single-Bit Subtract-and-Branch Processor Core

This block is a small stored-program processor with one instruction only. Each instruction names two single-bit data locations and a partial jump target. The core subtracts the value at the first location from the value at the second and stores the difference back in the second location. It then jumps to the partial target, with the lowest address bit set to 1 if the subtraction came out negative and 0 if it did not. Any other operation is built in software from sequences of this one instruction.

The instruction store and the data store sit outside the block. Each one serves one combinational read or one write per enabled cycle. The core steps every instruction through three separated phases, driven by a single clock. In the first phase it fetches the instruction and reads the first operand. In the second phase it reads the second operand. In the third phase it writes the result. An idle cycle precedes each phase, so one instruction takes six cycles.

The top bit of the instruction address selects one of two program halves. That bit is brought out as a task indicator. Two programs can share the core cooperatively, each one handing control to the other by jumping into the other half.

Top module: `subneg_core`

## Requirements
- R1: While reset is held (from the first clock edge in reset onward), no memory enable is asserted. The first instruction fetch comes in the cycle after the first clock edge with reset released, and it is fetched from address 0.
- R2: The instruction word is 10 bits. Bits [9:6] are the partial jump target, bits [5:3] are the first operand address A, and bits [2:0] are the second operand address B.
- R3: In the fetch phase, `imem_rd_en` and `dmem_rd_a_en` are both high. `imem_addr` carries the current instruction address, and `dmem_addr` carries the A field of the word returned in that same cycle.
- R4: Exactly two cycles after a fetch, `dmem_rd_b_en` is high and `dmem_addr` carries the B field of the fetched instruction.
- R5: Exactly four cycles after a fetch, `dmem_wr_en` is high with `dmem_addr` = B and `dmem_wdata` = mem[A] XOR mem[B]. The next fetch comes six cycles after the previous one.
- R6: The next instruction address is {partial target, n}, where n is 1 exactly when mem[A]=1 and mem[B]=0 (a negative result), and 0 otherwise.
- R7: `proc_id` equals bit 4 of the current instruction address. It changes only on the clock edge that ends a write phase.
- R8: At most one of `dmem_rd_a_en`, `dmem_rd_b_en` and `dmem_wr_en` is high in any cycle.
- R9: When A equals B, the value written is 0 and the low bit of the jump target is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| imem_rd_en | output | 1 | Instruction store read enable |
| imem_addr | output | 5 | Instruction address |
| imem_rdata | input | 10 | Instruction word returned in the same cycle |
| dmem_rd_a_en | output | 1 | Data read enable for operand A |
| dmem_rd_b_en | output | 1 | Data read enable for operand B |
| dmem_wr_en | output | 1 | Data write enable |
| dmem_addr | output | 3 | Data address for reads and writes |
| dmem_wdata | output | 1 | Data write value |
| dmem_rdata | input | 1 | Data value returned in the same cycle |
| proc_id | output | 1 | Running-program indicator (top instruction address bit) |

## Verification
Two functions can fall in the same cycle: the instruction fetch and the operand-A read. In that cycle the data address is steered straight from the instruction word that is arriving. The end of a write phase also lands on one clock edge together with the jump-target update, and with it any change of `proc_id`. Random programs combined with random data exercise all four operand combinations, jumps that cross between the program halves, and instructions whose two operands are the same location. A bench model computes each expected fetch address, write address and write value from its own copy of the data. A reset applied in the middle of an instruction checks that a cut-off write never reaches the store.

// File: rtl/subneg_pkg.sv
// Package: shared widths and types for the single-bit subtract-and-branch core.
// Assumes an instruction holds a partial target followed by two data addresses.
package subneg_pkg;
    parameter int PART_W  = 4;                       // partial jump target bits
    parameter int DADDR_W = 3;                       // data address bits
    localparam int IADDR_W = PART_W + 1;             // full instruction address
    localparam int INSTR_W = PART_W + 2 * DADDR_W;   // instruction word bits

    // Instruction word: target in the top bits, then A, then B
    typedef struct packed {
        logic [PART_W-1:0]  part;
        logic [DADDR_W-1:0] src_a;
        logic [DADDR_W-1:0] dst_b;
    } insn_t;

    // Result pair latched ahead of the write phase
    typedef struct packed {
        logic diff;
        logic neg;
    } result_t;

    // One-hot phase slots
    typedef enum logic [2:0] {
        PH_FETCH = 3'b001,
        PH_READB = 3'b010,
        PH_WRITE = 3'b100
    } phase_e;
endpackage

// File: rtl/subneg_phase_seq.sv
// Module: phase sequencer. Produces the three instruction phases from one
// clock, each one preceded by an idle cycle, so a full instruction takes six
// cycles. Assumes synchronous active-low reset; reset parks it idle before fetch.
module subneg_phase_seq
    import subneg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    output logic [2:0] phase_act,
    output logic       pre_write
);
    logic [2:0] slot_q;
    logic       idle_q;

    // Alternate idle and active cycles; rotate the slot after each active one
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q <= PH_FETCH;
            idle_q <= 1'b1;
        end else if (idle_q) begin
            idle_q <= 1'b0;
        end else begin
            idle_q <= 1'b1;
            slot_q <= {slot_q[1:0], slot_q[2]};
        end
    end

    // Qualify the slot by the active cycle and flag the cycle ahead of write
    always_comb begin
        phase_act = idle_q ? 3'b000 : slot_q;
        pre_write = idle_q && (slot_q == PH_WRITE);
    end

    assert_slot_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(slot_q) == 1);
    assert_active_then_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_act != 3'b000) |=> (phase_act == 3'b000));
endmodule

// File: rtl/subneg_alu.sv
// Module: one-bit subtractor. Gives the difference bit and the sign of B - A.
// Assumes both operands are single bits that are already latched and stable.
module subneg_alu
    import subneg_pkg::*;
(
    input  logic    op_a,
    input  logic    op_b,
    output result_t res
);
    // Difference bit and borrow-out sign of B minus A
    always_comb begin
        res.diff = op_a ^ op_b;
        res.neg  = op_a & ~op_b;
    end

    // A negative one-bit result always leaves a difference bit of 1 (R6)
    always_comb begin
        assert_neg_implies_diff_R6: assert (!res.neg || res.diff);
    end
endmodule

// File: rtl/subneg_datapath.sv
// Module: latches and address steering. Captures the instruction and the
// operands, holds the result pair and the instruction address, and drives the
// memory addresses. Assumes the stores return read data in the enabled cycle.
module subneg_datapath
    import subneg_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [2:0]         phase_act,
    input  logic               pre_write,
    input  logic [INSTR_W-1:0] imem_rdata,
    input  logic               dmem_rdata,
    output logic [IADDR_W-1:0] pc,
    output logic [DADDR_W-1:0] dmem_addr,
    output logic               dmem_wdata
);
    insn_t   insn_q;
    insn_t   insn_in;
    logic    opa_q;
    logic    opb_q;
    result_t res_q;
    result_t res_d;
    logic [IADDR_W-1:0] pc_q;

    assign insn_in = insn_t'(imem_rdata);

    subneg_alu u_alu (
        .op_a (opa_q),
        .op_b (opb_q),
        .res  (res_d)
    );

    // Latch the instruction word and operand A in the fetch phase
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            insn_q <= '0;
            opa_q  <= 1'b0;
        end else if (phase_act[0]) begin
            insn_q <= insn_in;
            opa_q  <= dmem_rdata;
        end
    end

    // Latch operand B in the second phase
    always_ff @(posedge clk) begin
        if (!rst_n)            opb_q <= 1'b0;
        else if (phase_act[1]) opb_q <= dmem_rdata;
    end

    // Capture the result pair in the idle cycle just before the write phase
    always_ff @(posedge clk) begin
        if (!rst_n)         res_q <= '0;
        else if (pre_write) res_q <= res_d;
    end

    // Form the next address from the partial target and the sign at write end
    always_ff @(posedge clk) begin
        if (!rst_n)            pc_q <= '0;
        else if (phase_act[2]) pc_q <= {insn_q.part, res_q.neg};
    end

    // Steer A from the arriving word in fetch, otherwise B from the latch
    always_comb begin
        pc         = pc_q;
        dmem_addr  = phase_act[0] ? insn_in.src_a : insn_q.dst_b;
        dmem_wdata = res_q.diff;
    end

    assert_equal_ops_write_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_act[2] && insn_q.src_a == insn_q.dst_b) |-> (dmem_wdata == 1'b0));
    assert_pc_low_bit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(phase_act[2]) |-> (pc_q[0] == ($past(opa_q) & ~$past(opb_q))));
endmodule

// File: rtl/subneg_core.sv
// Module: top of the single-bit subtract-and-branch core. Connects the phase
// sequencer to the datapath and decodes the phases into memory enables.
// Assumes external stores with a combinational read and a clocked write.
module subneg_core
    import subneg_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    output logic                 imem_rd_en,
    output logic [IADDR_W-1:0]   imem_addr,
    input  logic [INSTR_W-1:0]   imem_rdata,
    output logic                 dmem_rd_a_en,
    output logic                 dmem_rd_b_en,
    output logic                 dmem_wr_en,
    output logic [DADDR_W-1:0]   dmem_addr,
    output logic                 dmem_wdata,
    input  logic                 dmem_rdata,
    output logic                 proc_id
);
    logic [2:0]         phase_act;
    logic               pre_write;
    logic [IADDR_W-1:0] pc;

    subneg_phase_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .phase_act (phase_act),
        .pre_write (pre_write)
    );

    subneg_datapath u_dp (
        .clk        (clk),
        .rst_n      (rst_n),
        .phase_act  (phase_act),
        .pre_write  (pre_write),
        .imem_rdata (imem_rdata),
        .dmem_rdata (dmem_rdata),
        .pc         (pc),
        .dmem_addr  (dmem_addr),
        .dmem_wdata (dmem_wdata)
    );

    // Decode the active phase into memory strobes and the task indicator
    always_comb begin
        imem_rd_en   = phase_act[0];
        dmem_rd_a_en = phase_act[0];
        dmem_rd_b_en = phase_act[1];
        dmem_wr_en   = phase_act[2];
        imem_addr    = pc;
        proc_id      = pc[IADDR_W-1];
    end

    assert_quiet_in_reset_R1: assert property (@(posedge clk)
        !rst_n |=> !(imem_rd_en || dmem_rd_a_en || dmem_rd_b_en || dmem_wr_en));
    assert_single_data_access_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({dmem_rd_a_en, dmem_rd_b_en, dmem_wr_en}));
    assert_readb_after_fetch_R4: assert property (@(posedge clk) disable iff (!rst_n)
        dmem_rd_b_en |-> $past(dmem_rd_a_en, 2));
    assert_write_after_readb_R5: assert property (@(posedge clk) disable iff (!rst_n)
        dmem_wr_en |-> $past(dmem_rd_b_en, 2));
    assert_task_switch_at_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(proc_id) |-> $past(dmem_wr_en));
endmodule

// File: tb/subneg_core_test.sv
// Bench: models both stores, runs random and directed programs, and checks
// every fetch, read and write against an independent reference of the core.
module subneg_core_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       imem_rd_en, dmem_rd_a_en, dmem_rd_b_en, dmem_wr_en;
    logic [4:0] imem_addr;
    logic [9:0] imem_rdata;
    logic [2:0] dmem_addr;
    logic       dmem_wdata, dmem_rdata, proc_id;

    logic [9:0] imem [32];
    logic [7:0] dmem;
    logic [7:0] ref_d;
    logic [4:0] ref_pc;
    logic [3:0] pend_part;
    logic [2:0] pend_a, pend_b;
    int n_cmp = 0, n_bad = 0, since = 0, rst_len = 0, cycles = 0, fetches = 0;
    bit first = 1'b1, have_insn = 1'b0, done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    subneg_core uut (.clk(clk), .rst_n(rst_n), .imem_rd_en(imem_rd_en),
        .imem_addr(imem_addr), .imem_rdata(imem_rdata), .dmem_rd_a_en(dmem_rd_a_en),
        .dmem_rd_b_en(dmem_rd_b_en), .dmem_wr_en(dmem_wr_en), .dmem_addr(dmem_addr),
        .dmem_wdata(dmem_wdata), .dmem_rdata(dmem_rdata), .proc_id(proc_id));

    assign imem_rdata = imem[imem_addr];
    assign dmem_rdata = dmem[dmem_addr];

    // Store model: one clocked write, blocked while reset is held
    always @(posedge clk) if (rst_n && dmem_wr_en) dmem[dmem_addr] <= dmem_wdata;

    function automatic logic [9:0] word(input logic [3:0] p, input logic [2:0] a, input logic [2:0] b);
        return {p, a, b};
    endfunction
    function automatic logic exp_neg(input logic a, input logic b);
        return a & ~b;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Reference monitor, sampled at the falling edge
    always @(negedge clk) begin
        cycles++;
        since++;
        if (!rst_n) begin
            if (rst_len >= 1)
                check(!(imem_rd_en | dmem_rd_a_en | dmem_rd_b_en | dmem_wr_en), "R1 quiet in reset",
                      {imem_rd_en, dmem_rd_a_en, dmem_rd_b_en, dmem_wr_en}, 0);
            rst_len++;
            ref_pc = '0; first = 1'b1; have_insn = 1'b0;
        end else begin
            rst_len = 0;
            check($countones({dmem_rd_a_en, dmem_rd_b_en, dmem_wr_en}) <= 1, "R8 single access",
                  $countones({dmem_rd_a_en, dmem_rd_b_en, dmem_wr_en}), 1);
            check(proc_id == ref_pc[4], "R7 proc_id", proc_id, ref_pc[4]);
            if (imem_rd_en) begin
                check(imem_addr == ref_pc, first ? "R1 first fetch" : "R6 next address", imem_addr, ref_pc);
                check(dmem_rd_a_en, "R3 A read with fetch", dmem_rd_a_en, 1);
                check(dmem_addr == imem[imem_addr][5:3], "R3 A address", dmem_addr, imem[imem_addr][5:3]);
                if (first) check(since == rst_len + 1 || since >= 1, "R1 fetch timing", since, 1);
                else       check(since == 6, "R5 instruction period", since, 6);
                {pend_part, pend_a, pend_b} = imem[imem_addr];   // R2 field layout
                first = 1'b0; have_insn = 1'b1; since = 0; fetches++;
            end
            if (dmem_rd_b_en) begin
                check(have_insn && since == 2, "R4 B read timing", since, 2);
                check(dmem_addr == pend_b, "R4 B address", dmem_addr, pend_b);
            end
            if (dmem_wr_en) begin
                check(have_insn && since == 4, "R5 write timing", since, 4);
                check(dmem_addr == pend_b, "R5 write address", dmem_addr, pend_b);
                check(dmem_wdata == (ref_d[pend_a] ^ ref_d[pend_b]),
                      (pend_a == pend_b) ? "R9 same-operand write" : "R5 write value",
                      dmem_wdata, ref_d[pend_a] ^ ref_d[pend_b]);
                ref_pc = {pend_part, exp_neg(ref_d[pend_a], ref_d[pend_b])};
                ref_d[pend_b] = ref_d[pend_a] ^ ref_d[pend_b];
            end
        end
    end

    task automatic do_reset(input int n);
        @(negedge clk); rst_n = 1'b0;
        repeat (n) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary
    always @(posedge clk) if (!done && cycles > 150000) begin
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        // Random programs with random data, several resets in between
        for (int run = 0; run < 6; run++) begin
            for (int i = 0; i < 32; i++) imem[i] = 10'($urandom());
            dmem = 8'($urandom());
            @(negedge clk); rst_n = 1'b0; ref_d = dmem;
            repeat (3) @(negedge clk);
            rst_n = 1'b1;
            repeat (600 + ($urandom() % 7)) @(negedge clk);
            // Cut an instruction short, then resume from address 0 (R1)
            rst_n = 1'b0;
            repeat (3) @(negedge clk);
            ref_d = dmem;
            rst_n = 1'b1;
            repeat (300) @(negedge clk);
        end
        // Directed: all operand pairs, equal operands, switch between halves
        for (int i = 0; i < 32; i++) imem[i] = word(4'd0, 3'd7, 3'd7);
        imem[0]  = word(4'd2, 3'd1, 3'd0);   // 1 from 0: negative, go to 5
        imem[5]  = word(4'd8, 3'd3, 3'd3);   // equal operands (R9), go to 16
        imem[16] = word(4'd1, 3'd0, 3'd2);   // 1 from 0 again: go to 3, other half
        imem[3]  = word(4'd0, 3'd4, 3'd5);   // 0 from 1: positive, back to 0
        dmem = 8'b0010_0010;
        @(negedge clk); rst_n = 1'b0; ref_d = dmem;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        repeat (200) @(negedge clk);
        check(fetches > 100, "R5 progress", fetches, 100);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule